// File: doc/BRIEF.md
# Half-Rate Interleaved PRBS7 Generator

This block produces the maximal-length pseudo-random bit stream defined by the polynomial x^7 + x^6 + 1, whose period is 127 bits. Its register core advances at half the bit rate: on every enabled clock it produces two consecutive sequence bits at once and presents them as a 2-bit word. A downstream 2:1 serializer, or a parallel consumer, takes bit 1 first and bit 0 second.

The seven state bits are split into two interleaved lanes. One lane holds the even-indexed stages and the other the odd-indexed stages. Each lane shifts only within itself. The new bit entering each lane is the exclusive-or of one stage from its own lane and one stage from the opposite lane, so the two lanes feed each other. A synchronous start input loads an all-ones seed, which keeps the register out of the all-zero lockup state. An enable input pauses and resumes the stream without losing its place. A 2-bit frame marker flags the word bit that carries the first bit of each period. Because the period is odd, that bit alternates between word positions from one period to the next.

Top module: `prbs7_halfrate_gen`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `pair_o` is 0, `pair_vld_o` is 0 and `frame_o` is 0. `rst` takes priority over `start`. No valid word appears until the first `start`.
- R2: The clock edge at which `start` is high loads the all-ones seed and outputs no valid word. The first valid word after that is 2'b11 and comes from the seed.
- R3: The valid words, read bit 1 then bit 0 in order, equal the serial sequence from a 7-bit register s that starts at all ones. At each step that register emits s[6] and becomes {s[5:0], s[6]^s[5]}.
- R4: The stream repeats every 127 bits. Any 127 consecutive bits hold 64 ones and 63 zeros.
- R5: `frame_o[1]` is high on a valid word whose bit 1 is bit 0 of a period. `frame_o[0]` is high on a valid word whose bit 0 is bit 0 of a period. At most one marker bit is ever set. The two positions alternate between consecutive periods.
- R6: On an edge with `en` low, the state and `pair_o` hold and `pair_vld_o` is 0. When `en` returns, the stream continues with no bit skipped or repeated.
- R7: `start` asserted while the stream is running restarts it from the seed, even with `en` high.
- R8: While running, the state is never all zero, and the stream never contains seven zeros in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one edge per bit pair |
| rst | input | 1 | Synchronous active-high reset, stops the generator |
| start | input | 1 | Synchronous load of the seed and start of the stream |
| en | input | 1 | Advance enable; low pauses the stream |
| pair_o | output | 2 | Two consecutive sequence bits, bit 1 earlier |
| pair_vld_o | output | 1 | High when `pair_o` carries a new word |
| frame_o | output | 2 | Period-start marker for word bit 1 or word bit 0 |

## Verification
Three input patterns are used. A long unbroken run of about four periods is compared against a serial reference stepped twice per word. It separates correct lane cross-feedback and bit ordering from swapped taps or a reversed word, and it shows whether the frame marker correctly alternates between positions. A run with irregular enable gaps shows whether paused cycles lose or repeat bits. A restart issued in mid-stream, and a reset asserted together with start, check the priority between the three controls. Ones-count, period and zero-run checks made on the recorded bits then confirm the maximal-length property on their own.

// File: rtl/prbs7_pkg.sv
`timescale 1ns/1ps
package prbs7_pkg;

  // Gather every second bit of v, starting at bit index par, into a packed lane.
  function automatic logic [31:0] lane_pick(input logic [31:0] v, input int par, input int cnt);
    logic [31:0] r;
    r = '0;
    for (int k = 0; k < cnt; k++) begin
      r[k] = v[2*k + par];
    end
    return r;
  endfunction

  // State that one serial step turns into st, for x^len + x^tap + 1.
  function automatic logic [31:0] state_before(input logic [31:0] st, input int len, input int tap);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < len - 1; i++) begin
      r[i] = st[i + 1];
    end
    r[len - 1] = st[0] ^ st[tap];
    return r;
  endfunction

endpackage

// File: rtl/prbs7_lane_group.sv
`timescale 1ns/1ps
module prbs7_lane_group #(
  parameter int                STAGES    = 4,
  parameter logic [STAGES-1:0] SEED_BITS = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  input  logic              din,
  output logic [STAGES-1:0] q
);

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= SEED_BITS;
        else if (adv)  q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= SEED_BITS;
        else if (adv)  q <= {q[STAGES-2:0], din};
      end
    end
  endgenerate

endmodule

// File: rtl/prbs7_frame_detect.sv
`timescale 1ns/1ps
module prbs7_frame_detect #(
  parameter int           LEN  = 7,
  parameter int           TAP  = 6,
  parameter logic [LEN-1:0] SEED = '1
) (
  input  logic [LEN-1:0] state,
  output logic [1:0]     mark
);
  import prbs7_pkg::*;

  localparam logic [31:0]    PRED_W = state_before(32'(SEED), LEN, TAP);
  localparam logic [LEN-1:0] PRED   = PRED_W[LEN-1:0];

  // Bit 1 of the next word starts a period when the state equals the seed;
  // bit 0 does when the state is one serial step before the seed.
  always_comb begin
    mark[1] = (state == SEED);
    mark[0] = (state == PRED);
  end

endmodule

// File: rtl/prbs7_pair_core.sv
`timescale 1ns/1ps
module prbs7_pair_core #(
  parameter int             LEN  = 7,
  parameter int             TAP  = 6,
  parameter logic [LEN-1:0] SEED = '1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           adv,
  output logic [LEN-1:0] state,
  output logic [1:0]     pair_next,
  output logic [1:0]     mark_next
);
  import prbs7_pkg::*;

  localparam int NEV = (LEN + 1) / 2;
  localparam int NOD = LEN / 2;
  localparam logic [31:0]    SEED_EV_W = lane_pick(32'(SEED), 0, NEV);
  localparam logic [31:0]    SEED_OD_W = lane_pick(32'(SEED), 1, NOD);
  localparam logic [NEV-1:0] SEED_EV   = SEED_EV_W[NEV-1:0];
  localparam logic [NOD-1:0] SEED_OD   = SEED_OD_W[NOD-1:0];

  logic [NEV-1:0] q_ev;
  logic [NOD-1:0] q_od;
  logic           fb_hi;
  logic           fb_lo;

  // Even-indexed stages.
  prbs7_lane_group #(.STAGES(NEV), .SEED_BITS(SEED_EV)) u_even (
    .clk (clk), .rst (rst), .load (load), .adv (adv), .din (fb_lo), .q (q_ev)
  );

  // Odd-indexed stages.
  prbs7_lane_group #(.STAGES(NOD), .SEED_BITS(SEED_OD)) u_odd (
    .clk (clk), .rst (rst), .load (load), .adv (adv), .din (fb_hi), .q (q_od)
  );

  genvar k;
  generate
    for (k = 0; k < NEV; k++) begin : g_ev
      assign state[2*k] = q_ev[k];
    end
    for (k = 0; k < NOD; k++) begin : g_od
      assign state[2*k+1] = q_od[k];
    end
  endgenerate

  // Two serial steps per edge: the earlier new bit lands at index 1 (odd lane),
  // the later one at index 0 (even lane). Each sum mixes both lanes.
  assign fb_hi     = state[LEN-1] ^ state[TAP-1];
  assign fb_lo     = state[LEN-2] ^ state[TAP-2];
  assign pair_next = {state[LEN-1], state[LEN-2]};

  prbs7_frame_detect #(.LEN(LEN), .TAP(TAP), .SEED(SEED)) u_mark (
    .state (state),
    .mark  (mark_next)
  );

endmodule

// File: rtl/prbs7_halfrate_gen.sv
`timescale 1ns/1ps
module prbs7_halfrate_gen #(
  parameter int             LEN  = 7,
  parameter int             TAP  = 6,
  parameter logic [LEN-1:0] SEED = '1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       en,
  output logic [1:0] pair_o,
  output logic       pair_vld_o,
  output logic [1:0] frame_o
);

  logic           running_q;
  logic           step;
  logic [LEN-1:0] core_state;
  logic [1:0]     pair_next;
  logic [1:0]     mark_next;

  assign step = running_q & en & ~start;

  always_ff @(posedge clk) begin
    if (rst)        running_q <= 1'b0;
    else if (start) running_q <= 1'b1;
  end

  prbs7_pair_core #(.LEN(LEN), .TAP(TAP), .SEED(SEED)) u_core (
    .clk       (clk),
    .rst       (rst),
    .load      (start),
    .adv       (step),
    .state     (core_state),
    .pair_next (pair_next),
    .mark_next (mark_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pair_o     <= '0;
      pair_vld_o <= 1'b0;
      frame_o    <= '0;
    end else if (step) begin
      pair_o     <= pair_next;
      pair_vld_o <= 1'b1;
      frame_o    <= mark_next;
    end else begin
      pair_vld_o <= 1'b0;
      frame_o    <= '0;
    end
  end

endmodule

// File: rtl/prbs7_gen_checker.sv
`timescale 1ns/1ps
module prbs7_gen_checker #(
  parameter int             LEN  = 7,
  parameter logic [LEN-1:0] SEED = '1
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           en,
  input logic           running,
  input logic [LEN-1:0] state,
  input logic [1:0]     pair_o,
  input logic           pair_vld_o,
  input logic [1:0]     frame_o
);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!pair_vld_o && pair_o == 2'b00 && frame_o == 2'b00)); // R1

  AST_START_SEED: assert property (@(posedge clk) disable iff (rst)
    start |=> (state == SEED && !pair_vld_o)); // R2

  AST_ADVANCE_VALID: assert property (@(posedge clk) disable iff (rst)
    (running && en && !start) |=> pair_vld_o); // R3

  AST_SEED_MARK: assert property (@(posedge clk) disable iff (rst)
    (running && en && !start && state == SEED) |=> (pair_o == 2'b11 && frame_o == 2'b10)); // R5

  AST_MARK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(frame_o)); // R5

  AST_MARK_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    (frame_o != 2'b00) |-> pair_vld_o); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en && !start) |=> (!pair_vld_o && $stable(pair_o))); // R6

  AST_START_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    (start && en) |=> !pair_vld_o); // R7

  AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (rst)
    running |-> (state != '0)); // R8

endmodule

bind prbs7_halfrate_gen prbs7_gen_checker #(.LEN(LEN), .SEED(SEED)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .en         (en),
  .running    (running_q),
  .state      (core_state),
  .pair_o     (pair_o),
  .pair_vld_o (pair_vld_o),
  .frame_o    (frame_o)
);

// File: tb/tb_prbs7_halfrate_gen.sv
`timescale 1ns/1ps
module tb_prbs7_halfrate_gen;

  typedef struct {
    logic       vld;
    logic [1:0] pair;
    logic [1:0] frame;
    logic       rec;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       en = 1'b0;
  logic [1:0] pair_o;
  logic       pair_vld_o;
  logic [1:0] frame_o;

  int   n_checks = 0;
  int   n_errors = 0;
  exp_t sb_q[$];
  logic got_bits[$];
  logic rec_mode = 1'b0;
  string cur_tag = "R1";

  // reference model state
  logic [6:0] m_state = '0;
  logic       m_run = 1'b0;
  logic [1:0] m_pair = '0;
  int         m_idx = 0;

  always #2.5 clk = ~clk;

  prbs7_halfrate_gen dut (
    .clk (clk), .rst (rst), .start (start), .en (en),
    .pair_o (pair_o), .pair_vld_o (pair_vld_o), .frame_o (frame_o)
  );

  task automatic step(input logic r, input logic s, input logic e);
    exp_t it;
    logic b1, b0;
    @(negedge clk);
    rst = r; start = s; en = e;
    it.rec = rec_mode;
    it.tag = cur_tag;
    it.vld = 1'b0;
    it.frame = 2'b00;
    if (r) begin
      m_run = 1'b0; m_state = '0; m_idx = 0; m_pair = 2'b00;
    end else if (s) begin
      m_run = 1'b1; m_state = 7'h7F; m_idx = 0;
    end else if (m_run && e) begin
      b1 = m_state[6];
      m_state = {m_state[5:0], m_state[6] ^ m_state[5]};
      b0 = m_state[6];
      m_state = {m_state[5:0], m_state[6] ^ m_state[5]};
      m_pair = {b1, b0};
      it.vld = 1'b1;
      it.frame = {m_idx == 0, m_idx == 126};
      m_idx = (m_idx + 2) % 127;
    end
    it.pair = m_pair;
    sb_q.push_back(it);
  endtask

  // monitor / scoreboard
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        n_checks++;
        if (pair_vld_o !== e.vld || pair_o !== e.pair || frame_o !== e.frame) begin
          n_errors++;
          $display("FAIL %s: vld/pair/frame actual %b/%b/%b expected %b/%b/%b",
                   e.tag, pair_vld_o, pair_o, frame_o, e.vld, e.pair, e.frame);
        end
        if (e.rec && pair_vld_o === 1'b1) begin
          got_bits.push_back(pair_o[1]);
          got_bits.push_back(pair_o[0]);
        end
      end
    end
  end

  task automatic final_check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    int ones, mism, run0, maxrun;
    // R1: reset with start and en high, then no stream before start
    cur_tag = "R1";
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1);
    // R2: start loads the seed; R3/R4/R5/R8: long recorded run
    cur_tag = "R2";
    step(1'b0, 1'b1, 1'b1);
    rec_mode = 1'b1;
    step(1'b0, 1'b0, 1'b1);
    cur_tag = "R3_R5";
    for (int i = 0; i < 299; i++) step(1'b0, 1'b0, 1'b1);
    rec_mode = 1'b0;
    // R6: irregular enable gaps
    cur_tag = "R6";
    for (int i = 0; i < 60; i++) step(1'b0, 1'b0, (i % 3 != 0) && (i % 7 != 5));
    // R7: restart in mid-stream with en high
    cur_tag = "R7";
    step(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 140; i++) step(1'b0, 1'b0, 1'b1);
    // R1: reset in mid-stream
    cur_tag = "R1";
    step(1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b1);
    repeat (4) @(negedge clk);

    // R4: ones count over two windows, and 127-bit repetition
    final_check(got_bits.size() == 600, "R4 recorded length", got_bits.size(), 600);
    if (got_bits.size() == 600) begin
      for (int w = 0; w < 2; w++) begin
        ones = 0;
        for (int i = 0; i < 127; i++) ones += (got_bits[w*127 + i] === 1'b1) ? 1 : 0;
        final_check(ones == 64, "R4 ones per period", ones, 64);
      end
      mism = 0;
      for (int i = 0; i < 600 - 127; i++) if (got_bits[i] !== got_bits[i+127]) mism++;
      final_check(mism == 0, "R4 period 127 mismatches", mism, 0);
      // R8: no run of seven zeros
      run0 = 0; maxrun = 0;
      for (int i = 0; i < 600; i++) begin
        run0 = (got_bits[i] === 1'b0) ? run0 + 1 : 0;
        if (run0 > maxrun) maxrun = run0;
      end
      final_check(maxrun < 7, "R8 longest zero run (limit 6)", maxrun, 6);
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule